// File: doc/BRIEF.md
# Multichannel Transmit Fill Engine

This block services the transmit side of four serial channels in hardware. When a service request arrives, it captures the transmit half (the upper nibble) of an 8-bit interrupt status vector. It then visits every flagged channel, highest channel first. For each one it moves bytes from that channel's 16-entry circular queue into the UART's transmit holding FIFO, and stops when the FIFO reports that it is full. If the queue is empty, or runs dry while the engine is filling, the engine writes a shut-off command to that channel's transmitter and records the shutdown in a 4-bit transmitter-down field. A disabled transmitter cannot raise the same request again and again.

The producer fills the queues through a simple write port, which rejects a write when the target queue is full. The producer also owns the down field through set-mask and clear-mask strobes: after refilling a queue and restarting a channel, it clears that channel's down bit. The UART is reached through a small register bus with three selectable registers: status, data and command. Read data returns one cycle after a read strobe.

The controller runs as a state machine with eight states. IDLE waits for a request. SCAN tests the flag of the current channel. CHKQ compares that channel's get and put pointers. RDST issues the status read. WAIT takes the returned status. WRDAT writes the head byte and pops it. WROFF writes the shut-off command and marks the channel down. NEXT shifts the saved flags and steps one channel lower, or returns to IDLE after channel 0.

The transitions are:
- IDLE goes to SCAN on a request with a non-zero nibble.
- SCAN goes to CHKQ when the channel is flagged, and to NEXT otherwise.
- CHKQ goes to WROFF when the queue is empty, and to RDST otherwise.
- RDST always goes to WAIT.
- WAIT goes to WRDAT when the status says ready, and to NEXT otherwise.
- WRDAT returns to CHKQ.
- WROFF goes to NEXT.
- NEXT goes to SCAN, or to IDLE after channel 0.

Top module: `txfill_engine`

## Requirements
- R1: A service request whose irq_vec[7:4] is all zero starts no pass. busy stays low and no bus read or write occurs. While idle, the bus is quiet.
- R2: irq_vec bit 4+i requests service of channel i (bit 4 is channel 0). A channel whose bit is clear sees no bus access, and its queue is left untouched.
- R3: Within one pass, flagged channels are serviced in descending order: channel 3, then 2, then 1, then 0.
- R4: When a flagged channel's queue is empty, the engine writes 0x08 to the command register (bus_reg = 2) of that channel. The channel's tx_down bit reads 1 from the next cycle, unless it is cleared in that same cycle.
- R5: When a flagged channel has queued data but status bit 2 (transmit ready) reads 0, the engine leaves that channel: no data write, no command write, and no change to tx_down.
- R6: While the queue holds data and status bit 2 reads 1, the engine writes the oldest queued byte to the data register (bus_reg = 1), pops it, and checks the queue again. Bytes come out in the order they were written.
- R7: A queue that empties during filling receives the shut-off command (R4) in the same pass, right after its last data byte.
- R8: down_set and down_clr set and clear tx_down bits one per mask bit. When both strobes hit the same bit in the same cycle, the bit ends up cleared.
- R9: Each queue holds 16 bytes. A producer write (q_wr) to a full queue raises q_reject in the same cycle and does not change the queue.
- R10: Every status read (bus_rd, bus_reg = 0) lasts one cycle. The following cycle carries no bus access, and the returned data is taken in that cycle.
- R11: After reset, busy and tx_down are 0 and all queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| svc_req | input | 1 | Start a service pass using irq_vec |
| irq_vec | input | 8 | Interrupt status vector; the upper half holds the transmit requests |
| busy | output | 1 | A pass is in progress |
| bus_rd | output | 1 | UART register read strobe |
| bus_wr | output | 1 | UART register write strobe |
| bus_reg | output | 2 | Register select: 0 status, 1 data, 2 command |
| bus_ch | output | 2 | Channel addressed on the bus |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_rd |
| q_wr | input | 1 | Producer queue write |
| q_ch | input | 2 | Queue selected by the producer |
| q_data | input | 8 | Byte to enqueue |
| q_reject | output | 1 | Write refused because the queue is full |
| down_set | input | 4 | Mask of tx_down bits to set |
| down_clr | input | 4 | Mask of tx_down bits to clear (wins over set) |
| tx_down | output | 4 | Transmitter-down flags, one per channel |

## Verification
A wrong channel index or a stale pending-flag register shows on the bus as a write to the wrong channel or a write in the wrong order. The write log of that same pass exposes it. A get-pointer or empty-flag error appears as a wrong, repeated or missing data byte, or as a misplaced shut-off command, which is visible at the next data write. A fault in the down field is visible on tx_down one cycle after the command write or the producer strobe.

// File: rtl/txfill_pkg.sv
package txfill_pkg;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_DATA = 2'd1,
        REG_CMD  = 2'd2
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_CHKQ,
        S_RDST,
        S_WAIT,
        S_WRDAT,
        S_WROFF,
        S_NEXT
    } fill_state_e;

    localparam logic [7:0] CMD_TX_OFF = 8'h08;
    localparam int         TXRDY_BIT  = 2;

endpackage

// File: rtl/txfill_qbank.sv
module txfill_qbank #(
    parameter int NCH   = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(NCH),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wr_ch,
    input  logic [DW-1:0] wr_data,
    output logic          reject,
    input  logic          pop,
    input  logic [CW-1:0] head_ch,
    output logic [DW-1:0] head_data,
    output logic          head_empty
);

    logic [NCH-1:0]         full_v;
    logic [NCH-1:0]         empty_v;
    logic [NCH-1:0][DW-1:0] head_v;

    for (genvar g = 0; g < NCH; g++) begin : g_q
        logic [DW-1:0] mem [DEPTH];
        logic [AW:0]   wp;
        logic [AW:0]   rp;
        logic          push_g;
        logic          pop_g;

        assign empty_v[g] = (wp == rp);
        assign full_v[g]  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
        assign head_v[g]  = mem[rp[AW-1:0]];
        assign push_g     = wr && (wr_ch == CW'(g)) && !full_v[g];
        assign pop_g      = pop && (head_ch == CW'(g)) && !empty_v[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wp <= '0;
                rp <= '0;
            end else begin
                if (push_g) wp <= wp + 1'b1;
                if (pop_g)  rp <= rp + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (push_g) mem[wp[AW-1:0]] <= wr_data;
        end
    end

    assign reject     = wr && full_v[wr_ch];
    assign head_data  = head_v[head_ch];
    assign head_empty = empty_v[head_ch];

endmodule

// File: rtl/txfill_downreg.sv
module txfill_downreg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_eng,
    input  logic [NCH-1:0] set_prod,
    input  logic [NCH-1:0] clr_prod,
    output logic [NCH-1:0] down
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) down <= '0;
        else        down <= (down | set_eng | set_prod) & ~clr_prod;
    end

endmodule

// File: rtl/txfill_fsm.sv
module txfill_fsm
    import txfill_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           svc_req,
    input  logic [NCH-1:0] req_nib,
    input  logic           head_empty,
    input  logic [DW-1:0]  head_data,
    input  logic [DW-1:0]  bus_rdata,
    output logic [CW-1:0]  cur_ch,
    output logic           pop,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic [1:0]     bus_reg,
    output logic [DW-1:0]  bus_wdata,
    output logic [NCH-1:0] set_down,
    output logic           busy
);

    fill_state_e    state, nxt;
    logic [NCH-1:0] pend;
    logic [CW-1:0]  ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            ch   <= '0;
        end else if (state == S_IDLE && svc_req && |req_nib) begin
            pend <= req_nib;
            ch   <= CW'(NCH - 1);
        end else if (state == S_NEXT) begin
            pend <= pend << 1;
            if (ch != '0) ch <= ch - 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (svc_req && |req_nib) nxt = S_SCAN;
            S_SCAN:  nxt = pend[NCH-1] ? S_CHKQ : S_NEXT;
            S_CHKQ:  nxt = head_empty ? S_WROFF : S_RDST;
            S_RDST:  nxt = S_WAIT;
            S_WAIT:  nxt = bus_rdata[TXRDY_BIT] ? S_WRDAT : S_NEXT;
            S_WRDAT: nxt = S_CHKQ;
            S_WROFF: nxt = S_NEXT;
            S_NEXT:  nxt = (ch == '0) ? S_IDLE : S_SCAN;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_reg   = REG_STAT;
        bus_wdata = '0;
        pop       = 1'b0;
        set_down  = '0;
        unique case (state)
            S_RDST: begin
                bus_rd  = 1'b1;
                bus_reg = REG_STAT;
            end
            S_WRDAT: begin
                bus_wr    = 1'b1;
                bus_reg   = REG_DATA;
                bus_wdata = head_data;
                pop       = 1'b1;
            end
            S_WROFF: begin
                bus_wr       = 1'b1;
                bus_reg      = REG_CMD;
                bus_wdata    = DW'(CMD_TX_OFF);
                set_down[ch] = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy   = (state != S_IDLE);
    assign cur_ch = ch;

endmodule

// File: rtl/txfill_engine.sv
module txfill_engine #(
    parameter int NCH   = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           svc_req,
    input  logic [2*NCH-1:0] irq_vec,
    output logic           busy,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic [1:0]     bus_reg,
    output logic [CW-1:0]  bus_ch,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           q_wr,
    input  logic [CW-1:0]  q_ch,
    input  logic [DW-1:0]  q_data,
    output logic           q_reject,
    input  logic [NCH-1:0] down_set,
    input  logic [NCH-1:0] down_clr,
    output logic [NCH-1:0] tx_down
);

    logic [CW-1:0]  cur_ch;
    logic           pop;
    logic           head_empty;
    logic [DW-1:0]  head_data;
    logic [NCH-1:0] set_eng;

    txfill_qbank #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW)) u_qbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (q_wr),
        .wr_ch      (q_ch),
        .wr_data    (q_data),
        .reject     (q_reject),
        .pop        (pop),
        .head_ch    (cur_ch),
        .head_data  (head_data),
        .head_empty (head_empty)
    );

    txfill_fsm #(.NCH(NCH), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_req    (svc_req),
        .req_nib    (irq_vec[2*NCH-1:NCH]),
        .head_empty (head_empty),
        .head_data  (head_data),
        .bus_rdata  (bus_rdata),
        .cur_ch     (cur_ch),
        .pop        (pop),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_reg    (bus_reg),
        .bus_wdata  (bus_wdata),
        .set_down   (set_eng),
        .busy       (busy)
    );

    txfill_downreg #(.NCH(NCH)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_eng  (set_eng),
        .set_prod (down_set),
        .clr_prod (down_clr),
        .down     (tx_down)
    );

    assign bus_ch = cur_ch;

endmodule

// File: rtl/txfill_checker.sv
module txfill_checker #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             svc_req,
    input logic [2*NCH-1:0] irq_vec,
    input logic             busy,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [1:0]       bus_reg,
    input logic [CW-1:0]    bus_ch,
    input logic             q_wr,
    input logic             q_reject,
    input logic [NCH-1:0]   down_clr,
    input logic [NCH-1:0]   tx_down
);

    AST_SKIP_EMPTY_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && svc_req && irq_vec[2*NCH-1:NCH] == '0) |=> !busy); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr)); // R1

    AST_OFF_MARKS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_reg == 2'd2 && down_clr == '0) |=> tx_down[$past(bus_ch)]); // R4

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (down_clr != '0) |=> ((tx_down & $past(down_clr)) == '0)); // R8

    AST_REJECT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        q_reject |-> q_wr); // R9

    AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (!bus_rd && !bus_wr)); // R10

    AST_READ_SELECTS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_reg == 2'd0 && !bus_wr)); // R10

endmodule

bind txfill_engine txfill_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_req  (svc_req),
    .irq_vec  (irq_vec),
    .busy     (busy),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_reg  (bus_reg),
    .bus_ch   (bus_ch),
    .q_wr     (q_wr),
    .q_reject (q_reject),
    .down_clr (down_clr),
    .tx_down  (tx_down)
);

// File: tb/test_txfill_engine.sv
`timescale 1ns/1ps
module test_txfill_engine;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       svc_req = 1'b0;
    logic [7:0] irq_vec = '0;
    logic       busy, bus_rd, bus_wr, q_reject;
    logic [1:0] bus_reg, bus_ch;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = '0;
    logic       q_wr = 1'b0;
    logic [1:0] q_ch = '0;
    logic [7:0] q_data = '0;
    logic [3:0] down_set = '0, down_clr = '0, tx_down;

    txfill_engine i_txfill_engine (
        .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .irq_vec(irq_vec),
        .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_reg(bus_reg),
        .bus_ch(bus_ch), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .q_wr(q_wr), .q_ch(q_ch), .q_data(q_data), .q_reject(q_reject),
        .down_set(down_set), .down_clr(down_clr), .tx_down(tx_down)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  mq [4][$];
    int          sp [4];
    logic [3:0]  edown = '0;
    logic [11:0] rec [$];
    logic [11:0] expq [$];
    int          nops = 0;

    // UART model: status returned the cycle after the read strobe.
    always @(posedge clk) begin
        if (bus_rd) bus_rdata <= (sp[bus_ch] > 0) ? 8'hA4 : 8'hA0;
    end

    // Bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (bus_rd || bus_wr) nops++;
        if (bus_wr) begin
            rec.push_back({bus_reg, bus_ch, bus_wdata});
            if (bus_reg == 2'd1) sp[bus_ch]--;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input int ch, input logic [7:0] d);
        bit exp_rej;
        @(negedge clk);
        q_wr = 1'b1; q_ch = 2'(ch); q_data = d;
        exp_rej = (mq[ch].size() >= 16);
        #1;
        check(q_reject == exp_rej, "R9 reject", int'(q_reject), int'(exp_rej));
        if (!exp_rej) mq[ch].push_back(d);
        @(negedge clk);
        q_wr = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] s, input logic [3:0] c);
        @(negedge clk);
        down_set = s; down_clr = c;
        @(negedge clk);
        down_set = '0; down_clr = '0;
        edown = (edown | s) & ~c;
        check(tx_down == edown, "R8 down strobe", int'(tx_down), int'(edown));
    endtask

    task automatic run_pass(input logic [7:0] vec, input int s0, input int s1,
                            input int s2, input int s3, input string req);
        int spx [4];
        int wd;
        sp[0] = s0; sp[1] = s1; sp[2] = s2; sp[3] = s3;
        spx = sp;
        expq.delete();
        rec.delete();
        for (int c = 3; c >= 0; c--) begin
            if (vec[4+c]) begin
                for (int k = 0; k < 40; k++) begin
                    if (mq[c].size() == 0) begin
                        expq.push_back({2'd2, 2'(c), 8'h08});
                        edown[c] = 1'b1;
                        break;
                    end
                    if (spx[c] == 0) break;
                    expq.push_back({2'd1, 2'(c), mq[c].pop_front()});
                    spx[c]--;
                end
            end
        end
        @(negedge clk);
        svc_req = 1'b1; irq_vec = vec;
        @(negedge clk);
        svc_req = 1'b0; irq_vec = '0;
        wd = 0;
        while (busy && wd < 2000) begin
            @(negedge clk);
            wd++;
        end
        check(rec.size() == expq.size(), {req, " write count"}, rec.size(), expq.size());
        for (int i = 0; i < expq.size() && i < rec.size(); i++)
            check(rec[i] == expq[i], {req, " write entry"}, int'(rec[i]), int'(expq[i]));
        check(tx_down == edown, {req, " R4 tx_down"}, int'(tx_down), int'(edown));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 4; c++) sp[c] = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy == 1'b0, "R11 busy", int'(busy), 0);
        check(tx_down == 4'h0, "R11 tx_down", int'(tx_down), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: lower nibble only, no pass
        nops = 0;
        @(negedge clk); svc_req = 1'b1; irq_vec = 8'h0F;
        @(negedge clk); svc_req = 1'b0; irq_vec = '0;
        repeat (5) @(negedge clk);
        check(nops == 0 && !busy, "R1 skip", nops, 0);

        // R11: all queues empty after reset -> flag all, every one shut off
        run_pass(8'hF0, 5, 5, 5, 5, "R11 R3 empty queues");
        strobe(4'h0, 4'hF);

        // R3 R6 R7 R2: mixed channels, ch2 unflagged
        for (int i = 0; i < 3; i++) push(1, 8'h10 + 8'(i));
        for (int i = 0; i < 2; i++) push(2, 8'h20 + 8'(i));
        run_pass(8'hB0, 0, 10, 0, 0, "R3 R6 R7 R2 mixed");

        // R5: ch2 flagged but FIFO full
        run_pass(8'h40, 0, 0, 0, 0, "R5 not ready");
        check(tx_down[2] == 1'b0, "R5 down unchanged", int'(tx_down[2]), 0);

        // R6: partial fill leaves remaining data, no shutdown
        push(2, 8'h22); push(2, 8'h23);
        run_pass(8'h40, 0, 0, 2, 0, "R6 partial fill");
        run_pass(8'h40, 0, 0, 9, 0, "R7 drain");

        // R9: fill 16, 17th rejected, drain proves it had no effect
        strobe(4'h0, 4'hF);
        for (int i = 0; i < 17; i++) push(3, 8'h80 + 8'(i));
        run_pass(8'h80, 0, 0, 0, 20, "R9 full queue drain");

        // R8: set, clear, and simultaneous set and clear
        strobe(4'h5, 4'h0);
        strobe(4'h0, 4'h1);
        strobe(4'h2, 4'h2);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            for (int c = 0; c < 4; c++) begin
                int n;
                n = $urandom_range(0, 6);
                for (int k = 0; k < n; k++) push(c, 8'($urandom));
            end
            if ($urandom_range(0, 1) == 1) strobe(4'h0, 4'($urandom));
            run_pass(8'($urandom), $urandom_range(0, 5), $urandom_range(0, 5),
                     $urandom_range(0, 5), $urandom_range(0, 5), "R3 R6 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule